// File: doc/BRIEF.md
# Clock Tolerance Compensation FIFO

This block is an elastic buffer that carries a stream of words from a write clock domain into an unrelated read clock domain. It absorbs the phase difference between the two clocks, and it can also absorb a small frequency difference. To do that it drops or repeats one programmable idle word. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses to the other side through a two-flop synchroniser, so each side computes a fill level from its own pointer and the delayed pointer of the other side.

When compensation is on and the write side sees the buffer filling up, it throws away incoming idle words. When the read side sees the buffer running low, it repeats an idle word that it has just taken from the buffer. Only idle words are ever touched, so the stream must carry idles often enough. When compensation is off, the block is a plain phase-compensation FIFO. The read side waits for a start level of stored words before it begins to stream. It falls back to waiting whenever it runs dry.

The configuration inputs `ctc_en` and `idle_code` are expected to be static while traffic flows. Each domain has its own synchronous active-high reset, and both resets are asserted together.

Top module: `ctc_fifo`

## Requirements
- R1: While the resets are high, and in the first cycles after them, `rd_valid`, `ins_pulse`, `udf_pulse`, `del_pulse` and `ovf_pulse` are all low.
- R2: With `ctc_en` low, the valid words on the read side are exactly the accepted written words in the same order, and `ins_pulse` and `del_pulse` stay low.
- R3: After reset, `rd_valid` stays low until the read side counts START_FILL (default 8) stored words. After that the words stream out in order.
- R4: With `ctc_en` high, a written word equal to `idle_code` is discarded when the write-side fill is above HI_MARK (default 12). `del_pulse` is high for one `wr_clk` cycle, one cycle after that word was presented.
- R5: With `ctc_en` high, the read side repeats the previous output word when three conditions hold: that word equals `idle_code`, it was taken from the buffer (it was not itself a repeat), and the read-side fill is below LO_MARK (default 4). The repeat is presented with `ins_pulse` high and the buffer is not popped. Two insertions never occur on consecutive read cycles.
- R6: Without overflow, the sequence of non-idle words read equals the sequence written. The number of idle words read equals the idle words written, minus the deletions, plus the insertions.
- R7: A word written while the write side sees 16 stored words (2^AW) is discarded, and `ovf_pulse` is high for one cycle. Every accepted word is still read out in order.
- R8: When the read side is streaming and finds the buffer empty with no insertion possible, `udf_pulse` is high for one cycle with `rd_valid` low. The read side then waits again for START_FILL words.
- R9: Only words equal to the present `idle_code` can be deleted or repeated. Any other value, including a previously used idle code, passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| wr_valid | input | 1 | Write word present this cycle |
| wr_data | input | DW | Write word |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain synchronous reset, active high |
| rd_valid | output | 1 | Read word present this cycle |
| rd_data | output | DW | Read word |
| ctc_en | input | 1 | Enables idle deletion and insertion |
| idle_code | input | DW | Word value treated as the removable idle |
| ins_pulse | output | 1 | One read cycle per inserted idle |
| del_pulse | output | 1 | One write cycle per deleted idle |
| ovf_pulse | output | 1 | One write cycle per word lost to a full buffer |
| udf_pulse | output | 1 | One read cycle per run-dry event |

## Verification
The assertions check several rules on every cycle. Deletions occur only for valid words that match the idle code. An insertion always repeats an idle that was just output, and never twice in a row. No pulse fires with compensation off, and the paired status pulses never fire together. Each Gray pointer changes by at most one bit per cycle.

Other properties depend on whole streams and only the bench's traffic scenarios show them. These are word order and conservation across deletions and insertions, the exact drop count on overflow, the start threshold, and recovery after running dry. The bench drives a faster write clock and a slower one against the read clock to produce these cases.

// File: rtl/ctc_pkg.sv
`timescale 1ns/1ps
package ctc_pkg;
  // read side operating mode
  typedef enum logic {
    RD_FILL   = 1'b0,  // waiting for the start level
    RD_STREAM = 1'b1   // emitting one word per cycle
  } rd_mode_e;
endpackage

// File: rtl/ctc_ptr_sync.sv
`timescale 1ns/1ps
module ctc_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[PW-1] = sync_q[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ sync_q[i];
    end
  end
endmodule

// File: rtl/ctc_dpram.sv
`timescale 1ns/1ps
module ctc_dpram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, holds its value when not enabled
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctc_wr_ctl.sv
`timescale 1ns/1ps
module ctc_wr_ctl #(
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int HI_MARK = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          ctc_en,
  input  logic [DW-1:0] idle_code,
  input  logic [AW:0]   rbin_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wgray,
  output logic          del_pulse,
  output logic          ovf_pulse
);
  localparam int          PW    = AW + 1;
  localparam logic [PW-1:0] FULL_L = PW'(1 << AW);
  localparam logic [PW-1:0] HI_L   = PW'(HI_MARK);

  logic [PW-1:0] wbin;
  logic [PW-1:0] wbin_nx;
  logic [PW-1:0] wfill;
  logic          drop_idle;
  logic          full;
  logic          lost;

  assign wfill     = wbin - rbin_sync;
  assign full      = (wfill >= FULL_L);
  assign drop_idle = wr_valid && ctc_en && (wr_data == idle_code) && (wfill > HI_L);
  assign mem_we    = wr_valid && !drop_idle && !full;
  assign lost      = wr_valid && !drop_idle && full;
  assign mem_waddr = wbin[AW-1:0];
  assign wbin_nx   = wbin + PW'(mem_we);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wgray     <= '0;
      del_pulse <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      wbin      <= wbin_nx;
      wgray     <= wbin_nx ^ (wbin_nx >> 1);
      del_pulse <= drop_idle;
      ovf_pulse <= lost;
    end
  end
endmodule

// File: rtl/ctc_rd_ctl.sv
`timescale 1ns/1ps
module ctc_rd_ctl
  import ctc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int LO_MARK    = 4,
  parameter int START_FILL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctc_en,
  input  logic [DW-1:0] idle_code,
  input  logic [AW:0]   wbin_sync,
  input  logic [DW-1:0] rdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic          rd_valid,
  output logic          ins_pulse,
  output logic          udf_pulse
);
  localparam int            PW      = AW + 1;
  localparam logic [PW-1:0] LO_L    = PW'(LO_MARK);
  localparam logic [PW-1:0] START_L = PW'(START_FILL);

  rd_mode_e      mode;
  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nx;
  logic [PW-1:0] rfill;
  logic          empty;
  logic          from_mem;   // current output word was popped, not repeated
  logic          ins_c;
  logic          udf_c;
  logic          streaming;

  assign rfill     = wbin_sync - rbin;
  assign empty     = (rfill == '0);
  assign streaming = (mode == RD_STREAM);
  assign ins_c     = streaming && ctc_en && rd_valid && from_mem &&
                     (rdata == idle_code) && (rfill < LO_L);
  assign mem_re    = streaming && !ins_c && !empty;
  assign udf_c     = streaming && !ins_c && empty;
  assign mem_raddr = rbin[AW-1:0];
  assign rbin_nx   = rbin + PW'(mem_re);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= RD_FILL;
      rbin      <= '0;
      rgray     <= '0;
      rd_valid  <= 1'b0;
      from_mem  <= 1'b0;
      ins_pulse <= 1'b0;
      udf_pulse <= 1'b0;
    end else begin
      rbin      <= rbin_nx;
      rgray     <= rbin_nx ^ (rbin_nx >> 1);
      rd_valid  <= mem_re || ins_c;
      from_mem  <= mem_re;
      ins_pulse <= ins_c;
      udf_pulse <= udf_c;
      case (mode)
        RD_FILL:   if (rfill >= START_L) mode <= RD_STREAM;
        RD_STREAM: if (udf_c)            mode <= RD_FILL;
        default:                         mode <= RD_FILL;
      endcase
    end
  end
endmodule

// File: rtl/ctc_fifo.sv
`timescale 1ns/1ps
module ctc_fifo #(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int HI_MARK    = 12,
  parameter int LO_MARK    = 4,
  parameter int START_FILL = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ctc_en,
  input  logic [DW-1:0] idle_code,
  output logic          ins_pulse,
  output logic          del_pulse,
  output logic          ovf_pulse,
  output logic          udf_pulse
);
  localparam int PW = AW + 1;

  logic [PW-1:0] w_gray;
  logic [PW-1:0] r_gray;
  logic [PW-1:0] rbin_at_wr;
  logic [PW-1:0] wbin_at_rd;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic          mem_re;
  logic [AW-1:0] mem_raddr;

  ctc_ptr_sync #(.PW(PW)) u_rptr_sync (
    .clk     (wr_clk),
    .rst     (wr_rst),
    .gray_in (r_gray),
    .bin_out (rbin_at_wr)
  );

  ctc_ptr_sync #(.PW(PW)) u_wptr_sync (
    .clk     (rd_clk),
    .rst     (rd_rst),
    .gray_in (w_gray),
    .bin_out (wbin_at_rd)
  );

  ctc_wr_ctl #(.DW(DW), .AW(AW), .HI_MARK(HI_MARK)) u_wr (
    .clk       (wr_clk),
    .rst       (wr_rst),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .ctc_en    (ctc_en),
    .idle_code (idle_code),
    .rbin_sync (rbin_at_wr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .wgray     (w_gray),
    .del_pulse (del_pulse),
    .ovf_pulse (ovf_pulse)
  );

  ctc_dpram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .rrst  (rd_rst),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  ctc_rd_ctl #(.DW(DW), .AW(AW), .LO_MARK(LO_MARK), .START_FILL(START_FILL)) u_rd (
    .clk       (rd_clk),
    .rst       (rd_rst),
    .ctc_en    (ctc_en),
    .idle_code (idle_code),
    .wbin_sync (wbin_at_rd),
    .rdata     (rd_data),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .rgray     (r_gray),
    .rd_valid  (rd_valid),
    .ins_pulse (ins_pulse),
    .udf_pulse (udf_pulse)
  );
endmodule

// File: rtl/ctc_fifo_chk.sv
`timescale 1ns/1ps
module ctc_fifo_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_valid,
  input logic [DW-1:0] wr_data,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          ctc_en,
  input logic [DW-1:0] idle_code,
  input logic          ins_pulse,
  input logic          del_pulse,
  input logic          ovf_pulse,
  input logic          udf_pulse,
  input logic [AW:0]   w_gray,
  input logic [AW:0]   r_gray
);
  // write domain
  p_no_del_off_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !ctc_en |=> !del_pulse);
  p_del_idle_only_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_valid && (wr_data != idle_code)) |=> !del_pulse);
  p_del_needs_word_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_valid |=> !del_pulse);
  p_ovf_del_excl_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !(del_pulse && ovf_pulse));
  p_wgray_step_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  // read domain
  p_no_ins_off_r2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !ctc_en |=> !ins_pulse);
  p_ins_repeats_idle_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    ins_pulse |-> (rd_valid && (rd_data == idle_code) &&
                   $past(rd_valid) && ($past(rd_data) == idle_code)));
  p_ins_not_twice_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    ins_pulse |=> !ins_pulse);
  p_udf_no_word_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    udf_pulse |-> (!rd_valid && !ins_pulse));
  p_rgray_step_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind ctc_fifo ctc_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk    (wr_clk),
  .wr_rst    (wr_rst),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .rd_clk    (rd_clk),
  .rd_rst    (rd_rst),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .ctc_en    (ctc_en),
  .idle_code (idle_code),
  .ins_pulse (ins_pulse),
  .del_pulse (del_pulse),
  .ovf_pulse (ovf_pulse),
  .udf_pulse (udf_pulse),
  .w_gray    (w_gray),
  .r_gray    (r_gray)
);

// File: tb/test_ctc_fifo.sv
`timescale 1ns/1ps
module test_ctc_fifo;
  localparam int DW = 16;
  localparam logic [DW-1:0] CODE_A = 16'hF0BC;
  localparam logic [DW-1:0] CODE_B = 16'hE71C;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst = 1'b1;
  logic          rd_rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          ctc_en = 1'b0;
  logic [DW-1:0] idle_code = CODE_A;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          ins_pulse, del_pulse, ovf_pulse, udf_pulse;

  real wr_half = 5.0;
  always #5 rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  ctc_fifo i_ctc_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid), .rd_data(rd_data),
    .ctc_en(ctc_en), .idle_code(idle_code), .ins_pulse(ins_pulse),
    .del_pulse(del_pulse), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
  );

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] in_q[$];
  logic [DW-1:0] out_q[$];
  int ins_n, del_n, ovf_n, udf_n;
  bit writing = 0;
  logic [DW-1:0] seq;

  always @(negedge rd_clk) if (!rd_rst) begin
    if (rd_valid) out_q.push_back(rd_data);
    if (ins_pulse) ins_n++;
    if (udf_pulse && writing) udf_n++;
  end

  always @(negedge wr_clk) if (!wr_rst) begin
    if (del_pulse) del_n++;
    if (ovf_pulse) ovf_n++;
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic do_reset();
    @(negedge wr_clk);
    wr_valid = 1'b0;
    wr_rst = 1'b1;
    rd_rst = 1'b1;
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    @(negedge rd_clk);
    // R1: outputs quiet during reset
    check(!rd_valid && !ins_pulse && !udf_pulse && !del_pulse && !ovf_pulse,
          "R1", "flags in reset", int'({rd_valid, ins_pulse, udf_pulse, del_pulse, ovf_pulse}), 0);
    in_q.delete();
    out_q.delete();
    ins_n = 0; del_n = 0; ovf_n = 0; udf_n = 0;
    seq = 16'd1;
    @(negedge wr_clk) wr_rst = 1'b0;
    @(negedge rd_clk) rd_rst = 1'b0;
    repeat (3) @(negedge rd_clk);
    check(!rd_valid && !ins_pulse && !udf_pulse && !del_pulse && !ovf_pulse,
          "R1", "flags after reset", int'({rd_valid, ins_pulse, udf_pulse, del_pulse, ovf_pulse}), 0);
  endtask

  task automatic push_word(logic [DW-1:0] w);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = w;
    in_q.push_back(w);
  endtask

  // idles: insert code words; alt: sometimes send alt_code as plain data
  task automatic send(int n, bit idles, logic [DW-1:0] code, bit alt,
                      logic [DW-1:0] alt_code, bit gaps);
    int since = 0;
    writing = 1;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 8 == 0)) begin
        @(negedge wr_clk);
        wr_valid = 1'b0;
      end
      if (idles && (($urandom % 4 == 0) || since >= 4)) begin
        push_word(code);
        since = 0;
      end else if (alt && ($urandom % 10 == 0)) begin
        push_word(alt_code);
        since++;
      end else begin
        push_word(seq);
        seq++;
        since++;
      end
    end
    @(negedge wr_clk) wr_valid = 1'b0;
    writing = 0;
    repeat (120) @(negedge rd_clk);
  endtask

  task automatic compare(bit filt, logic [DW-1:0] code, string tag);
    logic [DW-1:0] a[$];
    logic [DW-1:0] b[$];
    int mism = -1;
    foreach (in_q[i])  if (!filt || in_q[i] != code)  a.push_back(in_q[i]);
    foreach (out_q[i]) if (!filt || out_q[i] != code) b.push_back(out_q[i]);
    check(a.size() == b.size(), tag, "word count", b.size(), a.size());
    foreach (b[i]) if (mism < 0 && i < a.size() && a[i] != b[i]) mism = i;
    check(mism < 0, tag, "first mismatch index", mism, -1);
  endtask

  task automatic idle_balance(logic [DW-1:0] code, string tag);
    int ii = 0;
    int oi = 0;
    foreach (in_q[i])  if (in_q[i] == code)  ii++;
    foreach (out_q[i]) if (out_q[i] == code) oi++;
    check(oi == ii - del_n + ins_n, tag, "idle words out", oi, ii - del_n + ins_n);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // start threshold
    wr_half = 5.0;
    ctc_en = 1'b0;
    do_reset();
    for (int i = 0; i < 7; i++) begin
      push_word(seq);
      seq++;
      @(negedge wr_clk) wr_valid = 1'b0;
    end
    repeat (60) @(negedge rd_clk);
    check(out_q.size() == 0, "R3", "words before start level", out_q.size(), 0);
    push_word(seq);
    seq++;
    @(negedge wr_clk) wr_valid = 1'b0;
    repeat (30) @(negedge rd_clk);
    check(out_q.size() == 8, "R3", "words after start level", out_q.size(), 8);
    compare(1'b0, CODE_A, "R3");

    // compensation off, matched clocks, idles and gaps present
    do_reset();
    ctc_en = 1'b0;
    idle_code = CODE_A;
    send(300, 1'b1, CODE_A, 1'b0, CODE_B, 1'b1);
    compare(1'b0, CODE_A, "R2");
    check(ins_n == 0 && del_n == 0, "R2", "ins+del pulses", ins_n + del_n, 0);

    // fast writer with idles: deletions
    wr_half = 4.8;
    do_reset();
    ctc_en = 1'b1;
    idle_code = CODE_A;
    send(600, 1'b1, CODE_A, 1'b0, CODE_B, 1'b0);
    check(del_n > 0, "R4", "deletions seen", del_n, 1);
    check(ovf_n == 0, "R4", "overflows with idles", ovf_n, 0);
    compare(1'b1, CODE_A, "R6");
    idle_balance(CODE_A, "R6");

    // slow writer with idles under a new code: insertions
    wr_half = 5.2;
    do_reset();
    ctc_en = 1'b1;
    idle_code = CODE_B;
    send(600, 1'b1, CODE_B, 1'b1, CODE_A, 1'b0);
    check(ins_n > 0, "R5", "insertions seen", ins_n, 1);
    check(udf_n == 0, "R5", "underflows while writing", udf_n, 0);
    compare(1'b1, CODE_B, "R9");
    idle_balance(CODE_B, "R6");

    // fast writer without idles, compensation off: overflow
    wr_half = 4.6;
    do_reset();
    ctc_en = 1'b0;
    idle_code = CODE_A;
    send(600, 1'b0, CODE_A, 1'b0, CODE_B, 1'b0);
    check(ovf_n > 0, "R7", "overflows seen", ovf_n, 1);
    check(out_q.size() + ovf_n == in_q.size(), "R7", "read plus dropped",
          out_q.size() + ovf_n, in_q.size());
    begin
      int bad = 0;
      for (int i = 1; i < out_q.size(); i++) if (out_q[i] <= out_q[i-1]) bad++;
      check(bad == 0, "R7", "order violations", bad, 0);
    end

    // slow writer without idles, compensation on: underflow
    wr_half = 5.4;
    do_reset();
    ctc_en = 1'b1;
    idle_code = CODE_A;
    send(600, 1'b0, CODE_A, 1'b0, CODE_B, 1'b0);
    check(udf_n > 0, "R8", "underflows seen", udf_n, 1);
    check(ins_n == 0, "R8", "insertions without idles", ins_n, 0);
    compare(1'b0, CODE_A, "R8");

    report();
  end
endmodule